// File: doc/BRIEF.md
# Cascadable Ripple Adder/Subtractor

This block adds or subtracts two unsigned or two's-complement operands under one mode input. It is a chain of one-bit full-adder cells. In subtract mode every bit of the second operand is inverted, and a one enters the lowest cell to complete the two's complement. The external carry input stays usable in both modes. It adds one when adding and acts as a borrow-in when subtracting. That lets several slices be chained into a wider operation.

The external carry output uses the same mode-relative polarity: a carry when adding, a borrow when subtracting. Each slice therefore re-applies the mode to the carry it receives and to the carry it hands on. The top module joins a parameterised number of narrow slices (two 4-bit slices by default) into one wider unit. Its results match a flat chain of the same total width. A signed-overflow flag is produced separately from the unsigned carry. The path from inputs to outputs is purely combinational.

Top module: `adsub_cascade`

## Requirements
- R1: With `subMode` = 0 and `carryIn` = 0, `{carryOut, result}` equals `opA + opB` taken to WIDTH+1 bits.
- R2: With `subMode` = 1 and `carryIn` = 0, `result` equals `opA - opB` modulo 2^WIDTH. `carryOut` is 1 exactly when `opA < opB` as unsigned values (borrow).
- R3: With `subMode` = 0, `carryIn` = 1 adds one: `{carryOut, result}` equals `opA + opB + 1`.
- R4: With `subMode` = 1, `carryIn` = 1 is a borrow-in. `result` equals `opA - opB - 1` modulo 2^WIDTH, and `carryOut` is 1 exactly when `opA < opB + 1`.
- R5: In add mode, `overflow` is 1 exactly when the two's-complement sum `opA + opB + carryIn` falls outside the signed WIDTH-bit range.
- R6: In subtract mode, `overflow` is 1 exactly when the two's-complement difference `opA - opB - carryIn` falls outside the signed WIDTH-bit range.
- R7: The cascade of slices produces, for every operand, mode and carry-in combination, the same result, carry and overflow as a flat chain of the total width. This covers operands whose top bit is set. Each slice also reports signed overflow for its own bits.
- R8: `overflow` and `carryOut` are independent. Both combinations occur: carry without overflow (0xFF + 0x01) and overflow without carry (0x7F + 0x01).
- R9: All outputs follow the inputs combinationally, with no clock edge between an input change and the updated outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | SLICE_W*SLICES | First operand (minuend when subtracting) |
| opB | input | SLICE_W*SLICES | Second operand (subtrahend when subtracting) |
| subMode | input | 1 | 0 = add, 1 = subtract |
| carryIn | input | 1 | Carry-in when adding, borrow-in when subtracting |
| result | output | SLICE_W*SLICES | Sum or difference |
| carryOut | output | 1 | Carry-out when adding, borrow-out when subtracting |
| overflow | output | 1 | Signed overflow of the whole operation |

## Verification
Every result of this block is due in the same time step as its stimulus, because no register lies between the operand pins and the outputs. The bench therefore changes the inputs away from any clock edge and samples one nanosecond later, with no edge in between. The directed R9 case deliberately drives just after a rising edge and reads before the next one. A registered path would show the stale value there.

// File: rtl/adsub_pkg.sv
package adsub_pkg;

  // Strobes from the mode control into the bit chain.
  typedef struct packed {
    logic invertB;       // complement the second operand
    logic cellCarryIn;   // raw carry entering the lowest cell
    logic flipCarryOut;  // turn the raw carry into carry/borrow polarity
  } adsubStrobes_t;

endpackage

// File: rtl/adsub_fa.sv
module adsub_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/adsub_ctrl.sv
module adsub_ctrl
  import adsub_pkg::*;
(
  input  logic          subMode,
  input  logic          carryIn,
  output adsubStrobes_t strobes
);
  // The external carry is mode-relative. A subtracting slice with no
  // borrow-in therefore feeds a one into its lowest cell.
  always_comb begin
    strobes              = '0;
    strobes.invertB      = subMode;
    strobes.cellCarryIn  = carryIn ^ subMode;
    strobes.flipCarryOut = subMode;
  end
endmodule

// File: rtl/adsub_datapath.sv
module adsub_datapath
  import adsub_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] opA,
  input  logic [SLICE_W-1:0] opB,
  input  adsubStrobes_t      strobes,
  output logic [SLICE_W-1:0] result,
  output logic               carryOut,
  output logic               overflow
);
  localparam int MSB = SLICE_W - 1;

  logic [SLICE_W-1:0] bEff;
  logic [SLICE_W:0]   chain;

  // Fully combinational inversion: every bit is assigned on every path.
  assign bEff     = opB ^ {SLICE_W{strobes.invertB}};
  assign chain[0] = strobes.cellCarryIn;

  for (genvar i = 0; i < SLICE_W; i++) begin : g_cell
    adsub_fa u_fa (
      .x (opA[i]),
      .y (bEff[i]),
      .ci(chain[i]),
      .s (result[i]),
      .co(chain[i+1])
    );
  end

  assign overflow = chain[MSB] ^ chain[SLICE_W];
  assign carryOut = chain[SLICE_W] ^ strobes.flipCarryOut;
endmodule

// File: rtl/adsub_slice.sv
module adsub_slice
  import adsub_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] opA,
  input  logic [SLICE_W-1:0] opB,
  input  logic               subMode,
  input  logic               carryIn,
  output logic [SLICE_W-1:0] result,
  output logic               carryOut,
  output logic               overflow
);
  adsubStrobes_t strobes;

  adsub_ctrl u_ctrl (
    .subMode(subMode),
    .carryIn(carryIn),
    .strobes(strobes)
  );

  adsub_datapath #(.SLICE_W(SLICE_W)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut),
    .overflow(overflow)
  );
endmodule

// File: rtl/adsub_cascade.sv
module adsub_cascade #(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 2
) (
  input  logic [SLICE_W*SLICES-1:0] opA,
  input  logic [SLICE_W*SLICES-1:0] opB,
  input  logic                      subMode,
  input  logic                      carryIn,
  output logic [SLICE_W*SLICES-1:0] result,
  output logic                      carryOut,
  output logic                      overflow
);
  localparam int W = SLICE_W * SLICES;

  // Carries between slices are in carry/borrow polarity. Each slice
  // re-applies the mode on entry and on exit.
  logic [SLICES:0]   linkCarry;
  logic [SLICES-1:0] sliceOvf;

  assign linkCarry[0] = carryIn;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    adsub_slice #(.SLICE_W(SLICE_W)) u_slice (
      .opA     (opA[s*SLICE_W +: SLICE_W]),
      .opB     (opB[s*SLICE_W +: SLICE_W]),
      .subMode (subMode),
      .carryIn (linkCarry[s]),
      .result  (result[s*SLICE_W +: SLICE_W]),
      .carryOut(linkCarry[s+1]),
      .overflow(sliceOvf[s])
    );
  end

  assign carryOut = linkCarry[SLICES];
  assign overflow = sliceOvf[SLICES-1];
endmodule

// File: rtl/adsub_checker.sv
module adsub_checker #(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 2
) (
  input logic [SLICE_W*SLICES-1:0] opA,
  input logic [SLICE_W*SLICES-1:0] opB,
  input logic                      subMode,
  input logic                      carryIn,
  input logic [SLICE_W*SLICES-1:0] result,
  input logic                      carryOut,
  input logic                      overflow,
  input logic [SLICES-1:0]         sliceOvf
);
  localparam int W  = SLICE_W * SLICES;
  localparam int M  = W - 1;
  localparam int LM = SLICE_W - 1;

  logic [W:0] sumRef;
  logic [W:0] difRef;

  assign sumRef = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, carryIn};
  assign difRef = {1'b0, opA} - {1'b0, opB} - {{W{1'b0}}, carryIn};

  always_comb begin
    if (!subMode) begin
      AST_ADD_RESULT: assert ({carryOut, result} == sumRef)
        else $error("add result mismatch");                      // R1
      AST_ADD_OVERFLOW: assert (overflow ==
          ((opA[M] == opB[M]) && (result[M] != opA[M])))
        else $error("add overflow mismatch");                    // R5
      AST_LOW_SLICE_OVF_ADD: assert (sliceOvf[0] ==
          ((opA[LM] == opB[LM]) && (result[LM] != opA[LM])))
        else $error("low slice add overflow mismatch");          // R7
    end else begin
      AST_SUB_RESULT: assert ({carryOut, result} == difRef)
        else $error("sub result mismatch");                      // R2
      AST_SUB_OVERFLOW: assert (overflow ==
          ((opA[M] != opB[M]) && (result[M] != opA[M])))
        else $error("sub overflow mismatch");                    // R6
      AST_LOW_SLICE_OVF_SUB: assert (sliceOvf[0] ==
          ((opA[LM] != opB[LM]) && (result[LM] != opA[LM])))
        else $error("low slice sub overflow mismatch");          // R7
    end
  end
endmodule

bind adsub_cascade adsub_checker #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_chk (
  .opA     (opA),
  .opB     (opB),
  .subMode (subMode),
  .carryIn (carryIn),
  .result  (result),
  .carryOut(carryOut),
  .overflow(overflow),
  .sliceOvf(sliceOvf)
);

// File: tb/tb_adsub_cascade.sv
`timescale 1ns/1ps
module tb_adsub_cascade;
  localparam int SW = 4;
  localparam int NS = 2;
  localparam int W  = SW * NS;
  localparam int NVEC = 14;

  // Entry layout: {mode, cin, a[7:0], b[7:0], sum[7:0], cout, ovf}
  localparam logic [27:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h7F, 8'h00, 8'h80, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h05, 8'h03, 8'h02, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h03, 8'h05, 8'hFE, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h80, 8'h01, 8'h7F, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h7F, 8'hFF, 8'h80, 1'b1, 1'b1},
    {1'b1, 1'b1, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'h80, 8'h00, 8'h7F, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'hB0, 8'h00, 8'hB0, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'hB0, 8'h10, 8'h9F, 1'b0, 1'b0}
  };

  logic         clk = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         subMode = 1'b0;
  logic         carryIn = 1'b0;
  logic [W-1:0] result;
  logic         carryOut;
  logic         overflow;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  adsub_cascade #(.SLICE_W(SW), .SLICES(NS)) dut (
    .opA     (opA),
    .opB     (opB),
    .subMode (subMode),
    .carryIn (carryIn),
    .result  (result),
    .carryOut(carryOut),
    .overflow(overflow)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic c,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    subMode = m;
    carryIn = c;
    opA     = a;
    opB     = b;
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    #3;
    // Idle inputs: outputs settle to zero with no clock involved (R9, R1)
    check("R9", "idle result", 16'(result), 16'h00);
    check("R9", "idle carry", 16'(carryOut), 16'h0);
    check("R9", "idle overflow", 16'(overflow), 16'h0);

    // Table of directed vectors
    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      string tr, to;
      v = VECS[i];
      drive(v[27], v[26], v[25:18], v[17:10]);
      if (!v[27]) tr = v[26] ? "R3" : "R1";
      else        tr = v[26] ? "R4" : "R2";
      to = v[27] ? "R6" : "R5";
      check(tr, $sformatf("vec%0d result", i), 16'(result), 16'(v[9:2]));
      check(tr, $sformatf("vec%0d carry", i), 16'(carryOut), 16'(v[1]));
      check(to, $sformatf("vec%0d overflow", i), 16'(overflow), 16'(v[0]));
    end

    // R8: carry without overflow, then overflow without carry
    drive(1'b0, 1'b0, 8'hFF, 8'h01);
    check("R8", "carry-only", 16'({carryOut, overflow}), 16'b10);
    drive(1'b0, 1'b0, 8'h7F, 8'h01);
    check("R8", "overflow-only", 16'({carryOut, overflow}), 16'b01);

    // R9: change just after an edge and read before the next one
    @(posedge clk);
    #2;
    drive(1'b1, 1'b0, 8'h10, 8'h20);
    check("R9", "same-cycle result", 16'(result), 16'hF0);
    check("R9", "same-cycle borrow", 16'(carryOut), 16'h1);

    // R7: exhaustive sweep against a behavioural reference
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b++) begin
            int sa, sb, sr, ur;
            logic [8:0] full;
            logic expOvf;
            string tr, to;
            drive(m[0], c[0], a[7:0], b[7:0]);
            sa = int'($signed(a[7:0]));
            sb = int'($signed(b[7:0]));
            if (m == 0) begin
              ur = a + b + c;
              sr = sa + sb + c;
              full = ur[8:0];
            end else begin
              ur = a - b - c;
              sr = sa - sb - c;
              full = {(ur < 0), ur[7:0]};
            end
            expOvf = (sr > 127) || (sr < -128);
            tr = m ? "R7/R2" : "R7/R1";
            to = m ? "R7/R6" : "R7/R5";
            if (result !== full[7:0] || carryOut !== full[8])
              check(tr, $sformatf("m=%0d c=%0d a=%h b=%h sum/carry", m, c, a, b),
                    16'({carryOut, result}), 16'(full));
            else
              checks++;
            if (overflow !== expOvf)
              check(to, $sformatf("m=%0d c=%0d a=%h b=%h overflow", m, c, a, b),
                    16'(overflow), 16'(expOvf));
            else
              checks++;
          end
        end
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule